// File: doc/BRIEF.md
# Masked write datapath for a two-bank graphics SDRAM

This block models the data side of a two-bank graphics synchronous DRAM with a 32-bit data bus, backed by a small on-chip array. It accepts commands that have already been decoded: row open, read, single-word write, eight-column block write, and loads of a colour register and a plane-mask register. Every write passes through three mask layers. Four byte masks keep whole bytes of the stored word unchanged. A write-per-bit plane mask, switched on or off for each bank when that bank's row is opened, keeps individual bit planes unchanged. A block write stores the colour register into up to eight neighbouring columns, and the low byte of the data bus picks which of the eight columns are written.

Reads return one word, with a latency of two clocks. The byte masks sampled with the read decide which bytes of that word are driven, and each byte has its own output enable. Refresh, power saving, analog timing and checks on command legality are not part of the block. The array holds `2 * 2^ROW_BITS * 2^COL_BITS` words.

Top module: `sgram_wpath`

## Requirements
- R1: After reset `dq_oe` and `dq_out` are all zero. Both banks use row 0 with write-per-bit off. The plane-mask and colour registers are zero, so writes issued before any row open store the full data word, apart from bytes that are byte-masked.
- R2: `cmd`=1 (open row) stores `addr[ROW_BITS-1:0]` as the open row of bank `bank`. It switches write-per-bit on for that bank when `sf`=1 and off when `sf`=0. The other bank is left unchanged. No other command changes either bank's write-per-bit setting.
- R3: `cmd`=5 loads `dq_in` into the colour register and `cmd`=6 loads it into the plane-mask register. The plane mask keeps its value through any number of other commands, including colour loads, until the next `cmd`=6.
- R4: `cmd`=3 (write) stores `dq_in` at column `addr[COL_BITS-1:0]` of the open row of `bank`. Byte i means bits 8i+7..8i. When `bmask[i]`=1, byte i of the stored word keeps its old value.
- R5: While write-per-bit is on for the addressed bank, each stored bit becomes (new AND plane) OR (old AND NOT plane). Byte masking is then applied on top of this. This holds for both normal writes and block writes.
- R6: `cmd`=4 (block write) ignores the low three column bits. For j = 0..7 it writes the colour register into column {addr[COL_BITS-1:3], j} when `dq_in[j]`=1, and leaves that column untouched when `dq_in[j]`=0. The byte masks apply to all eight columns.
- R7: `cmd`=2 (read) sampled at rising edge k reads the word at column `addr[COL_BITS-1:0]` of the open row of `bank`. After edge k+2 and until edge k+3, `dq_oe[i]` equals NOT `bmask[i]` as sampled at edge k. In that cycle, `dq_out` carries the word with every disabled byte at zero. In any cycle that does not follow a read in this way, `dq_oe` and `dq_out` are zero.
- R8: The two banks hold separate words and separate open rows: the same column and row in different banks are different storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Decoded command: 0 idle, 1 open row, 2 read, 3 write, 4 block write, 5 load colour, 6 load plane mask |
| bank | input | 1 | Bank select |
| addr | input | max(ROW_BITS,COL_BITS) | Row on open row, column on read and writes |
| sf | input | 1 | Write-per-bit select sampled with open row |
| dq_in | input | 8*BYTES | Write data, register load value, block column enables |
| bmask | input | BYTES | Byte masks for writes and read output gating |
| dq_out | output | 8*BYTES | Read data, zero in disabled bytes |
| dq_oe | output | BYTES | Per-byte output enable |

## Verification
On every cycle the assertions check three things: that the output enables appear exactly two clocks after a sampled read and follow the inverted byte masks, that the plane mask changes only on its own load command, and that a bank's write-per-bit flag changes only on a row open. The way the three mask layers combine into a stored word can only be seen by reading words back. The bench does this, scenario by scenario, against a reference array: masked and unmasked writes, plane masks kept across colour loads, partial block fills and bank separation. The final random mix covers orderings such as a read right after a write to the same word.

// File: rtl/sgram_wpath.sv
module sgram_wpath #(
  parameter int BYTES    = 4,
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [2:0]                            cmd,
  input  logic                                  bank,
  input  logic [((ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS)-1:0] addr,
  input  logic                                  sf,
  input  logic [8*BYTES-1:0]                    dq_in,
  input  logic [BYTES-1:0]                      bmask,
  output logic [8*BYTES-1:0]                    dq_out,
  output logic [BYTES-1:0]                      dq_oe
);
  localparam int DW    = 8 * BYTES;
  localparam int IW    = 1 + ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << IW;
  localparam logic [2:0] C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_BW  = 3'd4, C_LDC = 3'd5, C_LDM = 3'd6;

  logic [DW-1:0]       mem [DEPTH];
  logic [ROW_BITS-1:0] row_q [2];
  logic [1:0]          wpb_q;
  logic [DW-1:0]       color_q, pmask_q;

  logic          s1_v, s2_v;
  logic [DW-1:0] s1_d, s2_d;
  logic [BYTES-1:0] s1_m, s2_m;

  logic [DW-1:0] bkeep, s2_keep;
  for (genvar i = 0; i < BYTES; i++) begin : g_bytes
    assign bkeep[8*i +: 8]   = {8{bmask[i]}};
    assign s2_keep[8*i +: 8] = {8{s2_m[i]}};
  end

  wire [ROW_BITS-1:0] cur_row = row_q[bank];
  wire [COL_BITS-1:0] col     = addr[COL_BITS-1:0];
  wire [IW-1:0]       widx    = {bank, cur_row, col};
  wire [DW-1:0]       plane   = wpb_q[bank] ? pmask_q : '1;
  wire [DW-1:0]       wen     = plane & ~bkeep;

  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (cmd == C_WR)
        mem[widx] <= (dq_in & wen) | (mem[widx] & ~wen);
      else if (cmd == C_BW)
        for (int j = 0; j < 8; j++)
          if (dq_in[j])
            mem[{bank, cur_row, col[COL_BITS-1:3], 3'(j)}] <=
              (color_q & wen) | (mem[{bank, cur_row, col[COL_BITS-1:3], 3'(j)}] & ~wen);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q[0] <= '0;
      row_q[1] <= '0;
      wpb_q    <= '0;
      color_q  <= '0;
      pmask_q  <= '0;
    end else begin
      case (cmd)
        C_ACT: begin
          row_q[bank] <= addr[ROW_BITS-1:0];
          wpb_q[bank] <= sf;
        end
        C_LDC:   color_q <= dq_in;
        C_LDM:   pmask_q <= dq_in;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_d <= '0; s1_m <= '0;
      s2_v <= 1'b0; s2_d <= '0; s2_m <= '0;
      dq_out <= '0;
      dq_oe  <= '0;
    end else begin
      s1_v <= (cmd == C_RD);
      s1_d <= mem[widx];
      s1_m <= bmask;
      s2_v <= s1_v;
      s2_d <= s1_d;
      s2_m <= s1_m;
      dq_oe  <= s2_v ? ~s2_m : '0;
      dq_out <= s2_v ? (s2_d & ~s2_keep) : '0;
    end
  end
endmodule

module sgram_wpath_chk #(
  parameter int BYTES = 4,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cmd,
  input logic [BYTES-1:0] bmask,
  input logic [BYTES-1:0] dq_oe,
  input logic [1:0]       wpb_q,
  input logic [DW-1:0]    pmask_q
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(cmd, 3) != 3'd2) |-> dq_oe == '0); // R7

  AST_OE_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(cmd, 3) == 3'd2) |-> dq_oe == ~$past(bmask, 3)); // R7

  AST_PLANE_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(cmd) != 3'd6) |-> $stable(pmask_q)); // R3

  AST_WPB_ONLY_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(cmd) != 3'd1) |-> $stable(wpb_q)); // R2
endmodule

bind sgram_wpath sgram_wpath_chk #(.BYTES(BYTES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .bmask(bmask), .dq_oe(dq_oe),
  .wpb_q(wpb_q), .pmask_q(pmask_q)
);

// File: tb/test_sgram_wpath.sv
module test_sgram_wpath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic        bank = 1'b0;
  logic [4:0]  addr = '0;
  logic        sf = 1'b0;
  logic [31:0] dq_in = '0;
  logic [3:0]  bmask = '0;
  logic [31:0] dq_out;
  logic [3:0]  dq_oe;

  sgram_wpath i_sgram_wpath (.clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank),
    .addr(addr), .sf(sf), .dq_in(dq_in), .bmask(bmask), .dq_out(dq_out), .dq_oe(dq_oe));

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  string phase = "R1";

  logic [31:0] rm [256];
  int          rrow [2];
  logic [1:0]  rwpb = '0;
  logic [31:0] rmask = '0, rcolor = '0;
  logic        e1v = 0, e2v = 0, eov = 0;
  logic [31:0] e1d = '0, e2d = '0, eod = '0;
  logic [3:0]  e1m = '0, e2m = '0, eom = '0;
  string       e1t = "R1", e2t = "R1", eot = "R1";

  function automatic logic [31:0] bx(input logic [3:0] m);
    for (int i = 0; i < 4; i++) bx[8*i +: 8] = {8{m[i]}};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic b, input logic [3:0] bm);
    logic [31:0] we;
    we = (rwpb[b] ? rmask : 32'hFFFF_FFFF) & ~bx(bm);
    return (nw & we) | (old & ~we);
  endfunction

  always @(posedge clk) begin
    int base;
    if (!rst_n) begin
      rrow[0] = 0; rrow[1] = 0; rwpb = '0; rmask = '0; rcolor = '0;
      e1v = 0; e2v = 0; eov = 0;
    end else begin
      base = int'(bank) * 128 + rrow[bank] * 32;
      eov = e2v; eod = e2d; eom = e2m; eot = e2t;
      e2v = e1v; e2d = e1d; e2m = e1m; e2t = e1t;
      e1v = (cmd == 3'd2); e1d = rm[base + int'(addr)]; e1m = bmask; e1t = phase;
      case (cmd)
        3'd1: begin rrow[bank] = int'(addr[1:0]); rwpb[bank] = sf; end
        3'd3: rm[base + int'(addr)] = merge(rm[base + int'(addr)], dq_in, bank, bmask);
        3'd4: for (int j = 0; j < 8; j++)
                if (dq_in[j])
                  rm[base + int'(addr & 5'h18) + j] =
                    merge(rm[base + int'(addr & 5'h18) + j], rcolor, bank, bmask);
        3'd5: rcolor = dq_in;
        3'd6: rmask = dq_in;
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    logic [3:0]  xo;
    logic [31:0] xd;
    if (rst_n) begin
      xo = eov ? ~eom : 4'h0;
      xd = eov ? (eod & ~bx(eom)) : 32'h0;
      compared++;
      if (dq_oe !== xo || dq_out !== xd) begin
        mismatched++;
        $display("FAIL %s: oe=%h out=%h expected oe=%h out=%h", eot, dq_oe, dq_out, xo, xd);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic issue(input logic [2:0] c, input logic b, input int a, input logic s,
                       input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    cmd = c; bank = b; addr = 5'(a); sf = s; dq_in = d; bmask = m;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(3'd0, 1'b0, 0, 1'b0, 32'h0, 4'h0);
  endtask

  task automatic rd(input logic b, input int c, input logic [3:0] m);
    issue(3'd2, b, c, 1'b0, $urandom, m);
  endtask

  task automatic read_rows;
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 32; c++) rd(b[0], c, 4'(c & 1 ? 0 : $urandom));
    idle(3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: outputs idle after reset
    compared++;
    if (dq_oe !== 4'h0 || dq_out !== 32'h0) begin
      mismatched++;
      $display("FAIL R1: oe=%h out=%h expected 0 0", dq_oe, dq_out);
    end
    // R1: writes to row 0 before any open store full words
    phase = "R1";
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 32; c++) issue(3'd3, b[0], c, 1'b0, $urandom, 4'h0);
    read_rows();
    // R8: fill every row of both banks, read back bank by bank
    phase = "R8";
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 4; r++) begin
        issue(3'd1, b[0], r, 1'b0, 32'h0, 4'h0);
        for (int c = 0; c < 32; c++) issue(3'd3, b[0], c, 1'b0, $urandom, 4'h0);
      end
    issue(3'd1, 1'b0, 2, 1'b0, 32'h0, 4'h0);
    issue(3'd1, 1'b1, 2, 1'b0, 32'h0, 4'h0);
    read_rows();
    // R4: byte-masked normal writes
    phase = "R4";
    for (int i = 0; i < 80; i++) issue(3'd3, 1'($urandom), $urandom % 32, 1'b0, $urandom, 4'($urandom));
    read_rows();
    // R5 and R2: plane mask on bank 0 only, then switched off
    phase = "R5";
    issue(3'd6, 1'b0, 0, 1'b0, $urandom, 4'h0);
    issue(3'd1, 1'b0, 1, 1'b1, 32'h0, 4'h0);
    issue(3'd1, 1'b1, 1, 1'b0, 32'h0, 4'h0);
    for (int i = 0; i < 80; i++) issue(3'd3, 1'($urandom), $urandom % 32, 1'b0, $urandom, 4'($urandom));
    read_rows();
    phase = "R2";
    issue(3'd1, 1'b0, 1, 1'b0, 32'h0, 4'h0);
    issue(3'd1, 1'b1, 1, 1'b1, 32'h0, 4'h0);
    for (int i = 0; i < 80; i++) issue(3'd3, 1'($urandom), $urandom % 32, 1'b0, $urandom, 4'($urandom));
    read_rows();
    // R3: plane mask kept across colour loads
    phase = "R3";
    issue(3'd6, 1'b0, 0, 1'b0, 32'h0F0F_33CC, 4'h0);
    issue(3'd1, 1'b0, 3, 1'b1, 32'h0, 4'h0);
    issue(3'd1, 1'b1, 3, 1'b1, 32'h0, 4'h0);
    for (int i = 0; i < 40; i++) issue(3'd3, 1'($urandom), $urandom % 32, 1'b0, $urandom, 4'h0);
    issue(3'd5, 1'b0, 0, 1'b0, $urandom, 4'h0);
    idle(5);
    for (int i = 0; i < 40; i++) issue(3'd3, 1'($urandom), $urandom % 32, 1'b0, 32'hFFFF_FFFF, 4'h0);
    read_rows();
    // R6: block fills with partial column enables, masks on top
    phase = "R6";
    issue(3'd5, 1'b0, 0, 1'b0, $urandom, 4'h0);
    for (int i = 0; i < 30; i++) issue(3'd4, 1'($urandom), $urandom % 32, 1'b0, $urandom, 4'($urandom));
    issue(3'd1, 1'b0, 0, 1'b0, 32'h0, 4'h0);
    issue(3'd4, 1'b0, 13, 1'b0, 32'h0000_00A5, 4'h0);
    issue(3'd4, 1'b0, 23, 1'b0, 32'h0000_00FF, 4'h6);
    read_rows();
    // R7: every mask pattern, back to back and spaced
    phase = "R7";
    for (int m = 0; m < 16; m++) rd(1'($urandom), $urandom % 32, 4'(m));
    for (int m = 0; m < 16; m++) begin rd(1'b1, m, 4'(m)); idle(m % 3); end
    issue(3'd3, 1'b0, 7, 1'b0, $urandom, 4'h0);
    rd(1'b0, 7, 4'h0);
    idle(4);
    // mixed random traffic over all commands
    phase = "R5";
    for (int i = 0; i < 4000; i++)
      issue(3'($urandom % 7), 1'($urandom), $urandom % 32, 1'($urandom), $urandom, 4'($urandom));
    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule